// File: doc/BRIEF.md
# Multiplexed Port Stream Header Parser

This block sits on a single host-to-device byte channel that is shared by up to eight serial ports. Every message on the channel opens with a header byte. Bit 7 of that byte says whether payload or a command follows, and bits 2:0 name the target port. The parser forwards payload bytes to a single downstream byte interface, tagged with the port they belong to. It turns register-write commands and extended commands into single-cycle strobes that carry the port, the code and the parameter. Header classes it does not implement are reported on an error pulse, and the parser then treats the following byte as a new header.

A payload header is two bytes: bits 6:3 of the first byte and the whole second byte together form a 12-bit count, from 0 to 4095, of the payload bytes that follow. When the parser takes in that count, it compares it with the transmit credit that the surrounding logic reports for the addressed port. A count above the credit sets a sticky overflow flag, and the payload is still forwarded. The flag clears only on reset.

The state machine has six states. `ST_HDR` waits for a header. From it, a payload header goes to `ST_LEN_LO`, a class 0..7 command goes to `ST_REG_VAL`, a class 9 command goes to `ST_EXT_CODE`, and a reserved class stays in `ST_HDR` and raises an error. From `ST_LEN_LO` a zero count returns to `ST_HDR` and any other count goes to `ST_PAYLOAD`. `ST_PAYLOAD` returns to `ST_HDR` after the last payload byte. `ST_REG_VAL` returns to `ST_HDR` and emits a register strobe. `ST_EXT_CODE` always goes to `ST_EXT_PARAM`, and `ST_EXT_PARAM` returns to `ST_HDR` with either an extended strobe or an error.

Top module: `msp_stream_parser`

## Requirements
- R1: While reset is held, and just after it, `in_ready` is 1. `pay_valid`, `reg_stb`, `ext_stb`, `hdr_err` and `credit_ovf` are all 0.
- R2: In a header byte, bit 7 = 0 marks a payload header and bit 7 = 1 marks a command. Bits 2:0 give the port, and every forwarded payload byte carries that port on `pay_port`.
- R3: A payload header gives a count L = {first byte bits 6:3, second byte}. Exactly L bytes are then presented on `pay_valid`/`pay_data`, unchanged and in order. The byte that comes after them is parsed as a header.
- R4: A payload header with L = 0 forwards no bytes, and the very next byte is parsed as a header.
- R5: In the payload phase, `in_ready` equals `pay_ready`, so no byte is lost or duplicated under back-pressure. In every other phase, `in_ready` is 1.
- R6: Command class c = bits 6:3 in the range 0..7 is a two-byte command. One cycle after the second byte is accepted, `reg_stb` pulses with `reg_port` = port, `reg_addr` = c and `reg_val` = the second byte.
- R7: Command class 9 is three bytes long: a sub-code byte, then a parameter byte. If the sub-code is 0x00..0x09, `ext_stb` pulses one cycle after the parameter byte is accepted, carrying port, sub-code and parameter.
- R8: A class 9 command whose sub-code is above 0x09 still consumes all three bytes. It gives no `ext_stb`; instead it gives a `hdr_err` pulse one cycle after the parameter byte.
- R9: Command classes 8 and 0xA..0xF pulse `hdr_err` for one cycle, in the cycle after the header byte is accepted. The next byte is parsed as a fresh header.
- R10: When the count byte of a payload header is accepted and L is greater than the addressed port's credit (`tx_credit` bits [16p+15:16p]), `credit_ovf` becomes 1 in the next cycle and stays 1 until reset. The payload is still forwarded. L equal to the credit does not set the flag.
- R11: `reg_stb`, `ext_stb` and `hdr_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser accepts the input byte |
| tx_credit | input | NPORTS*CRED_W | Per-port transmit credit, port p at bits [CRED_W*p +: CRED_W] |
| pay_valid | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_port | output | 3 | Port the payload byte belongs to |
| pay_ready | input | 1 | Downstream accepts the payload byte |
| reg_stb | output | 1 | Register-write strobe |
| reg_port | output | 3 | Port of the register write |
| reg_addr | output | 3 | Register index |
| reg_val | output | 8 | Register value |
| ext_stb | output | 1 | Extended command strobe |
| ext_port | output | 3 | Port of the extended command |
| ext_code | output | 8 | Extended sub-code |
| ext_param | output | 8 | Extended parameter |
| hdr_err | output | 1 | Reserved class or unknown sub-code pulse |
| credit_ovf | output | 1 | Sticky payload-over-credit flag |

## Verification
The bench sends a zero-length payload header. A parser that entered the payload phase for it would swallow the next command as payload. It sends a 261-byte payload, which uses the upper length bits; a design that dropped bits 6:3 would return to header parsing after 5 bytes and misread the rest of the stream. Every reserved class is followed directly by a valid command, so a parser that tried to skip parameter bytes would lose that command's strobe. The credit boundary is tested with a count equal to the credit and with a count above it. The per-cycle payload compare runs while `pay_ready` and `in_valid` toggle, which exposes any byte that is dropped or repeated when the downstream stalls.

// File: rtl/msp_pkg.sv
package msp_pkg;
    localparam int BYTE_W        = 8;
    localparam int PORT_W        = 3;
    localparam int FIELD_W       = 4;
    localparam int REG_W         = 3;
    localparam int LEN_W         = FIELD_W + BYTE_W;
    localparam int REGWR_CLASSES = 8;
    localparam logic [FIELD_W-1:0] CLS_EXT       = 4'h9;
    localparam logic [BYTE_W-1:0]  EXT_LAST_CODE = 8'h09;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_LEN_LO,
        ST_PAYLOAD,
        ST_REG_VAL,
        ST_EXT_CODE,
        ST_EXT_PARAM
    } parse_state_t;

    typedef enum logic [1:0] {
        HK_DATA,
        HK_REGWR,
        HK_EXT,
        HK_RSVD
    } hdr_kind_t;
endpackage

// File: rtl/msp_hdr_decode.sv
module msp_hdr_decode
    import msp_pkg::*;
(
    input  logic [BYTE_W-1:0]  hdr_byte,
    output hdr_kind_t          kind,
    output logic [PORT_W-1:0]  port,
    output logic [FIELD_W-1:0] field
);
    assign port  = hdr_byte[PORT_W-1:0];
    assign field = hdr_byte[PORT_W +: FIELD_W];

    always_comb begin
        if (!hdr_byte[BYTE_W-1])
            kind = HK_DATA;
        else if (int'(field) < REGWR_CLASSES)
            kind = HK_REGWR;
        else if (field == CLS_EXT)
            kind = HK_EXT;
        else
            kind = HK_RSVD;
    end
endmodule

// File: rtl/msp_len_counter.sv
module msp_len_counter #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] count,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= count - 1'b1;
    end

    assign last = (count == {{(LEN_W-1){1'b0}}, 1'b1});

    // R3: a payload byte is never taken with an empty counter
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0));
endmodule

// File: rtl/msp_credit_check.sv
module msp_credit_check #(
    parameter int NPORTS = 8,
    parameter int CRED_W = 16,
    parameter int LEN_W  = 12,
    parameter int PORT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     check,
    input  logic [PORT_W-1:0]        port,
    input  logic [LEN_W-1:0]         len,
    input  logic [NPORTS*CRED_W-1:0] credits,
    output logic                     ovf
);
    localparam int CMP_W = LEN_W + CRED_W;

    logic [CRED_W-1:0] cred_arr [NPORTS];
    logic [CRED_W-1:0] sel;
    logic              exceeds;

    for (genvar g = 0; g < NPORTS; g++) begin : g_cred
        assign cred_arr[g] = credits[g*CRED_W +: CRED_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NPORTS; i++)
            if (int'(port) == i) sel = cred_arr[i];
    end

    assign exceeds = ({{CRED_W{1'b0}}, len} > {{LEN_W{1'b0}}, sel});

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (check && exceeds)
            ovf <= 1'b1;
    end

    // R10: flag is sticky and only rises after a length check
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    a_r10_rise_on_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(check));
    initial begin
        assert (CMP_W > LEN_W);
    end
endmodule

// File: rtl/msp_stream_parser.sv
module msp_stream_parser
    import msp_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int CRED_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    output logic                     in_ready,
    input  logic [NPORTS*CRED_W-1:0] tx_credit,
    output logic                     pay_valid,
    output logic [7:0]               pay_data,
    output logic [2:0]               pay_port,
    input  logic                     pay_ready,
    output logic                     reg_stb,
    output logic [2:0]               reg_port,
    output logic [2:0]               reg_addr,
    output logic [7:0]               reg_val,
    output logic                     ext_stb,
    output logic [2:0]               ext_port,
    output logic [7:0]               ext_code,
    output logic [7:0]               ext_param,
    output logic                     hdr_err,
    output logic                     credit_ovf
);
    parse_state_t        state_q, state_d;
    logic [PORT_W-1:0]   port_q;
    logic [FIELD_W-1:0]  field_q;
    logic [BYTE_W-1:0]   code_q;

    hdr_kind_t           dec_kind;
    logic [PORT_W-1:0]   dec_port;
    logic [FIELD_W-1:0]  dec_field;

    logic                hs;
    logic [LEN_W-1:0]    len_full;
    logic                len_zero;
    logic                cnt_load, cnt_dec, cnt_last;
    logic [LEN_W-1:0]    cnt;
    logic                len_check;
    logic                code_ok;

    msp_hdr_decode u_dec (
        .hdr_byte (in_data),
        .kind     (dec_kind),
        .port     (dec_port),
        .field    (dec_field)
    );

    assign in_ready  = (state_q == ST_PAYLOAD) ? pay_ready : 1'b1;
    assign hs        = in_valid && in_ready;
    assign len_full  = {field_q, in_data};
    assign len_zero  = (len_full == '0);
    assign cnt_load  = (state_q == ST_LEN_LO) && hs;
    assign cnt_dec   = (state_q == ST_PAYLOAD) && hs;
    assign len_check = (state_q == ST_LEN_LO) && hs;
    assign code_ok   = (code_q <= EXT_LAST_CODE);

    msp_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (len_full),
        .dec      (cnt_dec),
        .count    (cnt),
        .last     (cnt_last)
    );

    msp_credit_check #(
        .NPORTS (NPORTS),
        .CRED_W (CRED_W),
        .LEN_W  (LEN_W),
        .PORT_W (PORT_W)
    ) u_cred (
        .clk     (clk),
        .rst_n   (rst_n),
        .check   (len_check),
        .port    (port_q),
        .len     (len_full),
        .credits (tx_credit),
        .ovf     (credit_ovf)
    );

    // payload path passes straight through
    assign pay_valid = (state_q == ST_PAYLOAD) && in_valid;
    assign pay_data  = in_data;
    assign pay_port  = port_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR: if (hs) begin
                unique case (dec_kind)
                    HK_DATA:  state_d = ST_LEN_LO;
                    HK_REGWR: state_d = ST_REG_VAL;
                    HK_EXT:   state_d = ST_EXT_CODE;
                    HK_RSVD:  state_d = ST_HDR;
                    default:  state_d = ST_HDR;
                endcase
            end
            ST_LEN_LO:    if (hs) state_d = len_zero ? ST_HDR : ST_PAYLOAD;
            ST_PAYLOAD:   if (hs && cnt_last) state_d = ST_HDR;
            ST_REG_VAL:   if (hs) state_d = ST_HDR;
            ST_EXT_CODE:  if (hs) state_d = ST_EXT_PARAM;
            ST_EXT_PARAM: if (hs) state_d = ST_HDR;
            default:      state_d = ST_HDR;
        endcase
    end

    // state register and header capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            port_q  <= '0;
            field_q <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HDR && hs) begin
                port_q  <= dec_port;
                field_q <= dec_field;
            end
            if (state_q == ST_EXT_CODE && hs)
                code_q <= in_data;
        end
    end

    // registered command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_stb   <= 1'b0;
            reg_port  <= '0;
            reg_addr  <= '0;
            reg_val   <= '0;
            ext_stb   <= 1'b0;
            ext_port  <= '0;
            ext_code  <= '0;
            ext_param <= '0;
            hdr_err   <= 1'b0;
        end else begin
            reg_stb <= 1'b0;
            ext_stb <= 1'b0;
            hdr_err <= 1'b0;
            if (state_q == ST_HDR && hs && dec_kind == HK_RSVD)
                hdr_err <= 1'b1;
            if (state_q == ST_REG_VAL && hs) begin
                reg_stb  <= 1'b1;
                reg_port <= port_q;
                reg_addr <= field_q[REG_W-1:0];
                reg_val  <= in_data;
            end
            if (state_q == ST_EXT_PARAM && hs) begin
                if (code_ok) begin
                    ext_stb   <= 1'b1;
                    ext_port  <= port_q;
                    ext_code  <= code_q;
                    ext_param <= in_data;
                end else begin
                    hdr_err <= 1'b1;
                end
            end
        end
    end

    // R11: at most one command-side pulse per cycle
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_stb, ext_stb, hdr_err}));
    // R9: after an error the parser is waiting for a header
    a_r9_resync: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> (state_q == ST_HDR));
    // R3: payload only presented while bytes remain
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (cnt != '0));
    // R5: a stalled input leaves the remaining count untouched
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(cnt));
    // R6: register strobe follows the value byte
    a_r6_after_value: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stb |-> ($past(state_q) == ST_REG_VAL));
    // R7: only known sub-codes produce an extended strobe
    a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stb |-> (ext_code <= EXT_LAST_CODE));
endmodule

// File: tb/msp_stream_parser_test.sv
module msp_stream_parser_test;
    localparam int NP = 8;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready;
    logic [NP*CW-1:0] tx_credit;
    logic pay_valid, pay_ready = 1'b1;
    logic [7:0] pay_data;
    logic [2:0] pay_port;
    logic reg_stb, ext_stb, hdr_err, credit_ovf;
    logic [2:0] reg_port, reg_addr, ext_port;
    logic [7:0] reg_val, ext_code, ext_param;

    always #10 clk = ~clk;

    msp_stream_parser #(.NPORTS(NP), .CRED_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx_credit(tx_credit), .pay_valid(pay_valid),
        .pay_data(pay_data), .pay_port(pay_port), .pay_ready(pay_ready),
        .reg_stb(reg_stb), .reg_port(reg_port), .reg_addr(reg_addr),
        .reg_val(reg_val), .ext_stb(ext_stb), .ext_port(ext_port),
        .ext_code(ext_code), .ext_param(ext_param), .hdr_err(hdr_err),
        .credit_ovf(credit_ovf)
    );

    int n_checks = 0;
    int n_errs = 0;
    int cyc = 0;

    logic [7:0] q[$];

    // reference model state
    int m_state = 0;          // 0 hdr, 1 len, 2 payload, 3 regval, 4 extcode, 5 extparam
    int m_port = 0, m_hi = 0, m_reg = 0, m_cnt = 0, m_code = 0;
    bit e_reg = 0, e_ext = 0, e_err = 0, e_ovf = 0;
    int e_reg_port = 0, e_reg_addr = 0, e_reg_val = 0;
    int e_ext_port = 0, e_ext_code = 0, e_ext_param = 0;
    int n_reg_exp = 0, n_ext_exp = 0, n_err_exp = 0;
    int n_reg_got = 0, n_ext_got = 0, n_err_got = 0;

    function automatic int credit_of(int p);
        return 8 + 4 * p;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit m_ready();
        return (m_state == 2) ? pay_ready : 1'b1;
    endfunction

    // model update on every clock edge
    always @(posedge clk) begin
        int b, len, cls;
        e_reg = 0; e_ext = 0; e_err = 0;
        if (!rst_n) begin
            m_state = 0; e_ovf = 0; m_cnt = 0;
        end else if (in_valid && m_ready() && q.size() > 0) begin
            b = int'(q.pop_front());
            case (m_state)
                0: begin
                    m_port = b % 8;
                    cls = (b / 8) % 16;
                    if (b < 128) begin
                        m_hi = cls; m_state = 1;
                    end else if (cls < 8) begin
                        m_reg = cls; m_state = 3;
                    end else if (cls == 9) begin
                        m_state = 4;
                    end else begin
                        e_err = 1; n_err_exp++;
                    end
                end
                1: begin
                    len = m_hi * 256 + b;
                    if (len > credit_of(m_port)) e_ovf = 1;
                    if (len == 0) m_state = 0;
                    else begin m_cnt = len; m_state = 2; end
                end
                2: begin
                    m_cnt--;
                    if (m_cnt == 0) m_state = 0;
                end
                3: begin
                    e_reg = 1; e_reg_port = m_port; e_reg_addr = m_reg; e_reg_val = b;
                    n_reg_exp++; m_state = 0;
                end
                4: begin
                    m_code = b; m_state = 5;
                end
                default: begin
                    if (m_code <= 9) begin
                        e_ext = 1; e_ext_port = m_port; e_ext_code = m_code; e_ext_param = b;
                        n_ext_exp++;
                    end else begin
                        e_err = 1; n_err_exp++;
                    end
                    m_state = 0;
                end
            endcase
        end
    end

    // drive away from the edge, then compare
    always @(negedge clk) begin
        cyc++;
        in_valid = rst_n && (q.size() > 0) && (cyc % 5 != 3);
        in_data  = (q.size() > 0) ? q[0] : 8'h00;
        pay_ready = (cyc % 7 != 2);
        #1;
        if (rst_n) begin
            chk(in_ready == m_ready(), "R5 in_ready", int'(in_ready), int'(m_ready()));
            // R3/R4: payload presence follows the model's remaining count
            chk(pay_valid == (m_state == 2 && in_valid), "R3 pay_valid",
                int'(pay_valid), int'(m_state == 2 && in_valid));
            if (m_state == 2 && in_valid) begin
                chk(pay_data == in_data, "R3 pay_data", int'(pay_data), int'(in_data));
                chk(int'(pay_port) == m_port, "R2 pay_port", int'(pay_port), m_port);
            end
            chk(reg_stb == e_reg, "R6 reg_stb", int'(reg_stb), int'(e_reg));
            if (e_reg) begin
                chk(int'(reg_port) == e_reg_port, "R6 reg_port", int'(reg_port), e_reg_port);
                chk(int'(reg_addr) == e_reg_addr, "R6 reg_addr", int'(reg_addr), e_reg_addr);
                chk(int'(reg_val) == e_reg_val, "R6 reg_val", int'(reg_val), e_reg_val);
            end
            chk(ext_stb == e_ext, "R7 ext_stb", int'(ext_stb), int'(e_ext));
            if (e_ext) begin
                chk(int'(ext_port) == e_ext_port, "R7 ext_port", int'(ext_port), e_ext_port);
                chk(int'(ext_code) == e_ext_code, "R7 ext_code", int'(ext_code), e_ext_code);
                chk(int'(ext_param) == e_ext_param, "R7 ext_param", int'(ext_param), e_ext_param);
            end
            chk(hdr_err == e_err, "R8/R9 hdr_err", int'(hdr_err), int'(e_err));
            chk(credit_ovf == e_ovf, "R10 credit_ovf", int'(credit_ovf), int'(e_ovf));
            chk($countones({reg_stb, ext_stb, hdr_err}) <= 1, "R11 exclusive",
                $countones({reg_stb, ext_stb, hdr_err}), 1);
            if (reg_stb) n_reg_got++;
            if (ext_stb) n_ext_got++;
            if (hdr_err) n_err_got++;
        end
    end

    task automatic push_data_hdr(input int port, input int len);
        q.push_back(8'((((len / 256) % 16) * 8) + port));
        q.push_back(8'(len % 256));
    endtask

    initial begin
        for (int p = 0; p < NP; p++) tx_credit[p*CW +: CW] = 16'(credit_of(p));

        // payload of 3 on port 2
        push_data_hdr(2, 3);
        q.push_back(8'hA1); q.push_back(8'hA2); q.push_back(8'hA3);
        // R4: zero-length payload on port 5, followed by a register write
        push_data_hdr(5, 0);
        q.push_back(8'hB3); q.push_back(8'h5A);       // R6: port 3, reg 6
        q.push_back(8'hCF); q.push_back(8'h05); q.push_back(8'h11);   // R7
        q.push_back(8'hC8); q.push_back(8'h09); q.push_back(8'h00);   // R7 last code
        q.push_back(8'hC9); q.push_back(8'h0A); q.push_back(8'h33);   // R8
        q.push_back(8'hC4);                                           // R9 class 8
        push_data_hdr(6, 2);
        q.push_back(8'hD1); q.push_back(8'hD2);
        for (int c = 10; c < 16; c++) begin                           // R9 classes A..F
            q.push_back(8'(128 + c * 8 + c % 8));
            q.push_back(8'(128 + (c - 10) * 8 + c % 8));
            q.push_back(8'(c * 3));
        end
        // R10: length equal to credit leaves flag clear
        push_data_hdr(1, 12);
        for (int i = 0; i < 12; i++) q.push_back(8'(8'h40 + i));
        q.push_back(8'h80); q.push_back(8'h77);       // reg write port 0, reg 0
        // R10 and R3 upper bits: 261 bytes on port 0 (credit 8)
        push_data_hdr(0, 261);
        for (int i = 0; i < 261; i++) q.push_back(8'(i));
        q.push_back(8'hCB); q.push_back(8'h08); q.push_back(8'hEE);   // R7 port 3

        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(pay_valid == 1'b0, "R1 pay_valid", int'(pay_valid), 0);
        chk({reg_stb, ext_stb, hdr_err} == 3'b000, "R1 strobes",
            int'({reg_stb, ext_stb, hdr_err}), 0);
        chk(credit_ovf == 1'b0, "R1 credit_ovf", int'(credit_ovf), 0);
        rst_n = 1'b1;

        while (q.size() != 0 && cyc < 20000) @(posedge clk);
        if (q.size() != 0) chk(1'b0, "R3 watchdog stream stuck", q.size(), 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        #3;
        chk(n_reg_got == n_reg_exp, "R6 reg strobe total", n_reg_got, n_reg_exp);
        chk(n_ext_got == n_ext_exp, "R7 ext strobe total", n_ext_got, n_ext_exp);
        chk(n_err_got == n_err_exp, "R8 error total", n_err_got, n_err_exp);
        chk(n_err_exp == 8, "R9 reserved plus bad code count", n_err_exp, 8);
        chk(credit_ovf == 1'b1, "R10 flag held", int'(credit_ovf), 1);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule